// File: doc/BRIEF.md
# Backup-Powered Shutdown and Wake-Up Sequencer

This block lives in the always-on domain fed by the backup battery, so its registers keep their contents while the main supply is cut. It drives a shutdown output to the external main converter. Software starts a power-down by writing a one-shot command bit over a small register bus. The block then waits for one of three wake events and releases the shutdown output so that main power returns.

The three wake events work independently. The first is a real-time-clock alarm pulse, which counts only when its enable bit is set. The second is a selected edge on a wake-up pin, which passes through a two-flop synchronizer. The third is a release of the shutdown line from outside, for example by a jumper or push-button, which the block sees on a sensed copy of the line. A clear-on-read status register records which events caused the last wake.

Register map (bus_addr): 0 = command, 1 = mode, 2 = wake cause. The bus is a single-cycle strobe interface. Read data is registered.

Top module: `bkp_pwr_seq`

## Requirements
- R1: After a synchronous reset, shdn_out is 0, the mode register reads 0 and the wake-cause register reads 0.
- R2: A write to address 0 with bit 0 set while running sets shdn_out to 1 from the next clock edge. The command bit clears itself, so address 0 always reads 0.
- R3: In power-down, an alarm_pulse sampled high while mode bit 2 (alarm wake enable) is 1 clears shdn_out at that same edge and sets wake-cause bit 0.
- R4: An alarm_pulse while mode bit 2 is 0 does not end power-down.
- R5: Mode bits [1:0] select the pin edge: 01 = rising, 10 = falling, 11 = either. A selected edge on wake_pin in power-down clears shdn_out on the third rising clock edge after the pin changes, and sets wake-cause bit 1.
- R6: With mode bits [1:0] = 00, or for an edge that is not selected, wake_pin does not end power-down.
- R7: In power-down, once shdn_sense has been seen high through its two-flop synchronizer, a low shdn_sense counts as an external release. shdn_out clears on the third edge after shdn_sense falls, and wake-cause bit 2 is set.
- R8: After a wake, the block spends exactly one cycle in a wake state and then runs again. A shutdown command that arrives outside the running state is ignored. When several events occur in the same cycle, all of their cause bits are set.
- R9: A read of address 2 returns the wake-cause bits and clears them. A cause that is set in the same cycle as the read is kept.
- R10: Alarm pulses, pin edges and a low shdn_sense while running do not change shdn_out or the wake-cause register.
- R11: Address 1 reads back the mode register in bits [2:0], with the upper bits 0. bus_rdata is valid from the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| alarm_pulse | input | 1 | Alarm pulse from the real-time clock |
| wake_pin | input | 1 | Asynchronous wake-up pin |
| shdn_sense | input | 1 | Sensed level of the shutdown line (1 = power cut) |
| shdn_out | output | 1 | Shutdown request to the main converter (1 = cut) |

## Verification
Each result is due a fixed number of edges after its stimulus:
- The command and the alarm act on the first edge.
- Pin edges and an external release act on the third edge, because of the two synchronizer flops.
- Read data appears at the edge that samples the strobe.

A behavioural reference model in the bench updates at every rising edge from the same sampled inputs. The bench compares the model with shdn_out and bus_rdata at every falling edge, so a result that arrives one cycle early or late is caught. Directed checks sample shdn_out just before and just after the due edge, for the pin path and the release path.

// File: rtl/bkp_pwr_pkg.sv
package bkp_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2
  } pwr_state_e;

  localparam int unsigned CAUSE_W     = 3;
  localparam int unsigned CAUSE_ALARM = 0;
  localparam int unsigned CAUSE_PIN   = 1;
  localparam int unsigned CAUSE_REL   = 2;

  localparam int unsigned MODE_W      = 3;
  localparam int unsigned MODE_AL_BIT = 2;

  localparam int unsigned REG_CMD   = 0;
  localparam int unsigned REG_MODE  = 1;
  localparam int unsigned REG_CAUSE = 2;
endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bkp_edge_det.sv
module bkp_edge_det (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic [1:0] sel,
  output logic       hit
);
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel)
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      2'b11:   hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bkp_regs.sv
module bkp_regs
  import bkp_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [CAUSE_W-1:0]  set_cause,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                shdn_cmd,
  output logic [1:0]          edge_sel,
  output logic                alarm_en
);
  logic [MODE_W-1:0]  mode_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               sel_cmd, sel_mode, sel_cause;

  assign sel_cmd   = (bus_addr == ADDR_W'(REG_CMD));
  assign sel_mode  = (bus_addr == ADDR_W'(REG_MODE));
  assign sel_cause = (bus_addr == ADDR_W'(REG_CAUSE));

  // One-shot command: never stored, so it clears itself
  assign shdn_cmd = bus_wr & sel_cmd & bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      cause_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && sel_mode) mode_q <= bus_wdata[MODE_W-1:0];
      // A new cause set in the same cycle as a clearing read is kept
      cause_q <= ((bus_rd && sel_cause) ? '0 : cause_q) | set_cause;
      if (bus_rd) begin
        if (sel_mode)       bus_rdata <= DATA_W'(mode_q);
        else if (sel_cause) bus_rdata <= DATA_W'(cause_q);
        else                bus_rdata <= '0;
      end
    end
  end

  assign edge_sel = mode_q[1:0];
  assign alarm_en = mode_q[MODE_AL_BIT];
endmodule

// File: rtl/bkp_fsm.sv
module bkp_fsm
  import bkp_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               shdn_cmd,
  input  logic               alarm_hit,
  input  logic               pin_hit,
  input  logic               sense_lvl,
  output pwr_state_e         state,
  output logic               shdn_out,
  output logic               rel_hit,
  output logic [CAUSE_W-1:0] set_cause
);
  logic armed;

  // The line must be seen asserted before a low level counts as a release
  assign rel_hit = (state == ST_DOWN) & armed & ~sense_lvl;

  always_comb begin
    set_cause = '0;
    if (state == ST_DOWN) begin
      set_cause[CAUSE_ALARM] = alarm_hit;
      set_cause[CAUSE_PIN]   = pin_hit;
      set_cause[CAUSE_REL]   = rel_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      shdn_out <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= (state == ST_DOWN) ? (armed | sense_lvl) : 1'b0;
      unique case (state)
        ST_RUN: if (shdn_cmd) begin
          state    <= ST_DOWN;
          shdn_out <= 1'b1;
        end
        ST_DOWN: if (|set_cause) begin
          state    <= ST_WAKE;
          shdn_out <= 1'b0;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bkp_pwr_seq.sv
module bkp_pwr_seq
  import bkp_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              alarm_pulse,
  input  logic              wake_pin,
  input  logic              shdn_sense,
  output logic              shdn_out
);
  logic               shdn_cmd, alarm_en, pin_hit, rel_hit;
  logic               pin_s, sense_s;
  logic [1:0]         edge_sel;
  logic [CAUSE_W-1:0] set_cause;
  pwr_state_e         st;

  bkp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .set_cause(set_cause),
    .bus_rdata(bus_rdata), .shdn_cmd(shdn_cmd), .edge_sel(edge_sel),
    .alarm_en(alarm_en)
  );

  bkp_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d(wake_pin), .q(pin_s)
  );

  bkp_sync #(.STAGES(SYNC_STAGES)) u_sense_sync (
    .clk(clk), .rst(rst), .d(shdn_sense), .q(sense_s)
  );

  bkp_edge_det u_edge (
    .clk(clk), .rst(rst), .lvl(pin_s), .sel(edge_sel), .hit(pin_hit)
  );

  bkp_fsm u_fsm (
    .clk(clk), .rst(rst), .shdn_cmd(shdn_cmd),
    .alarm_hit(alarm_pulse & alarm_en), .pin_hit(pin_hit),
    .sense_lvl(sense_s), .state(st), .shdn_out(shdn_out),
    .rel_hit(rel_hit), .set_cause(set_cause)
  );
endmodule

// File: rtl/bkp_pwr_seq_chk.sv
module bkp_pwr_seq_chk
  import bkp_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         st,
  input logic               shdn_out,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               alarm_pulse,
  input logic               alarm_en,
  input logic               pin_hit,
  input logic               rel_hit,
  input logic [1:0]         edge_sel,
  input logic [CAUSE_W-1:0] set_cause
);
  p_cmd_cuts_power_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && bus_wr && bus_addr == ADDR_W'(REG_CMD) && bus_wdata[0]) |=> shdn_out);

  p_alarm_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DOWN && alarm_pulse && !alarm_en && !pin_hit && !rel_hit) |=> shdn_out);

  p_pin_off_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DOWN && edge_sel == 2'b00 && !alarm_pulse && !rel_hit) |=> shdn_out);

  p_wake_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAKE) |=> (st == ST_RUN && !shdn_out));

  p_wake_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(shdn_out) |-> $past(set_cause != '0));

  p_run_no_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_DOWN) |-> (set_cause == '0));
endmodule

bind bkp_pwr_seq bkp_pwr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .st(st), .shdn_out(shdn_out), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .alarm_pulse(alarm_pulse),
  .alarm_en(alarm_en), .pin_hit(pin_hit), .rel_hit(rel_hit),
  .edge_sel(edge_sel), .set_cause(set_cause)
);

// File: tb/bkp_pwr_seq_tb.sv
module bkp_pwr_seq_tb;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic alarm_pulse = 1'b0, wake_pin = 1'b0, jumper = 1'b0;
  logic shdn_sense, shdn_out;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  // External converter: line follows the request unless forced open
  assign shdn_sense = shdn_out & ~jumper;

  bkp_pwr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_pulse(alarm_pulse), .wake_pin(wake_pin),
    .shdn_sense(shdn_sense), .shdn_out(shdn_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int   m_st = 0;
  bit   m_shdn = 0, m_armed = 0;
  bit [2:0] m_mode = 0, m_stat = 0, m_cause;
  int   m_rd = 0;
  bit   pq[$] = '{0, 0, 0};
  bit   sq[$] = '{0, 0, 0};
  bit   rise, fall, pin_ok, al_ok, rel_ok, nx_armed;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_shdn = 0; m_armed = 0; m_mode = 0; m_stat = 0; m_rd = 0;
      pq = '{0, 0, 0}; sq = '{0, 0, 0};
    end else begin
      rise   = pq[1] && !pq[2];
      fall   = !pq[1] && pq[2];
      pin_ok = (m_mode[1:0] == 2'b01 && rise) || (m_mode[1:0] == 2'b10 && fall) ||
               (m_mode[1:0] == 2'b11 && (rise || fall));
      al_ok  = alarm_pulse && m_mode[2];
      rel_ok = m_armed && !sq[1];
      nx_armed = (m_st == 1) ? (m_armed || sq[1]) : 1'b0;
      m_cause = 3'b000;
      if (m_st == 0) begin
        if (bus_wr && bus_addr == 0 && bus_wdata[0]) begin m_st = 1; m_shdn = 1; end
      end else if (m_st == 1) begin
        m_cause = {rel_ok, pin_ok, al_ok};
        if (m_cause != 0) begin m_st = 2; m_shdn = 0; end
      end else m_st = 0;
      m_armed = nx_armed;
      if (bus_rd) begin
        if (bus_addr == 1) m_rd = int'(m_mode);
        else if (bus_addr == 2) begin m_rd = int'(m_stat); m_stat = 0; end
        else m_rd = 0;
      end
      m_stat |= m_cause;
      if (bus_wr && bus_addr == 1) m_mode = bus_wdata[2:0];
      pq.push_front(wake_pin); void'(pq.pop_back());
      sq.push_front(shdn_sense); void'(sq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 shdn_out vs model", int'(shdn_out), int'(m_shdn));
      chk("R9 bus_rdata vs model", int'(bus_rdata), m_rd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic pulse_alarm();
    alarm_pulse = 1'b1;
    @(negedge clk);
    alarm_pulse = 1'b0;
  endtask

  initial begin
    int v;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 shdn_out after reset", int'(shdn_out), 0);
    rd(2, v); chk("R1 cause after reset", v, 0);
    rd(1, v); chk("R1 mode after reset", v, 0);

    // Alarm wake
    wr(1, 4);
    rd(1, v); chk("R11 mode readback", v, 4);
    wr(0, 1);
    chk("R2 shdn_out after command", int'(shdn_out), 1);
    rd(0, v); chk("R2 command self-clears", v, 0);
    cyc(4);
    chk("R3 no wake without source", int'(shdn_out), 1);
    pulse_alarm();
    chk("R3 alarm wake", int'(shdn_out), 0);
    rd(2, v); chk("R3 alarm cause", v, 1);
    rd(2, v); chk("R9 cause cleared by read", v, 0);

    // Alarm disabled, then external release
    wr(1, 0);
    wr(0, 1);
    pulse_alarm();
    cyc(3);
    chk("R4 disabled alarm ignored", int'(shdn_out), 1);
    jumper = 1'b1;
    cyc(2);
    chk("R7 release not yet due", int'(shdn_out), 1);
    cyc(1);
    chk("R7 release wake", int'(shdn_out), 0);
    jumper = 1'b0;
    cyc(2);
    rd(2, v); chk("R7 release cause", v, 4);

    // Events while running
    wr(1, 7);
    pulse_alarm();
    wake_pin = 1'b1; cyc(4);
    wake_pin = 1'b0; cyc(4);
    chk("R10 shdn_out idle in run", int'(shdn_out), 0);
    rd(2, v); chk("R10 no cause in run", v, 0);

    // Rising edge select
    wr(1, 1);
    wake_pin = 1'b1; cyc(4);
    wr(0, 1); cyc(4);
    wake_pin = 1'b0; cyc(5);
    chk("R6 falling edge ignored on rise select", int'(shdn_out), 1);
    wake_pin = 1'b1;
    cyc(2);
    chk("R5 pin wake not yet due", int'(shdn_out), 1);
    cyc(1);
    chk("R5 rising wake", int'(shdn_out), 0);
    cyc(2);
    rd(2, v); chk("R5 pin cause", v, 2);

    // Falling edge select
    wr(1, 2);
    wr(0, 1); cyc(4);
    wake_pin = 1'b0; cyc(3);
    chk("R5 falling wake", int'(shdn_out), 0);

    // Either edge
    wr(1, 3);
    wr(0, 1); cyc(4);
    wake_pin = 1'b1; cyc(3);
    chk("R5 either edge rise", int'(shdn_out), 0);
    cyc(2);
    wr(0, 1); cyc(4);
    wake_pin = 1'b0; cyc(3);
    chk("R5 either edge fall", int'(shdn_out), 0);
    cyc(2);
    rd(2, v); chk("R5 pin cause either", v, 2);

    // Pin wake disabled
    wr(1, 0);
    wr(0, 1); cyc(4);
    wake_pin = 1'b1; cyc(4);
    wake_pin = 1'b0; cyc(4);
    chk("R6 pin disabled", int'(shdn_out), 1);
    jumper = 1'b1; cyc(3);
    jumper = 1'b0;
    chk("R7 release exits", int'(shdn_out), 0);
    cyc(2);
    rd(2, v); chk("R6 only release cause", v, 4);

    // Simultaneous alarm and release
    wr(1, 4);
    wr(0, 1); cyc(4);
    jumper = 1'b1; cyc(2);
    pulse_alarm();
    jumper = 1'b0;
    chk("R8 joint wake", int'(shdn_out), 0);
    cyc(2);
    rd(2, v); chk("R8 both causes", v, 5);

    // Read coinciding with a wake
    wr(0, 1); cyc(4);
    alarm_pulse = 1'b1; bus_rd = 1'b1; bus_addr = 2'd2;
    @(negedge clk);
    alarm_pulse = 1'b0; bus_rd = 1'b0;
    chk("R9 read in wake cycle sees old", int'(bus_rdata), 0);
    // Command during the wake cycle is ignored
    wr(0, 1);
    chk("R8 command in wake ignored", int'(shdn_out), 0);
    rd(2, v); chk("R9 coinciding cause kept", v, 1);
    wr(0, 1);
    chk("R8 new shutdown accepted", int'(shdn_out), 1);
    pulse_alarm();
    chk("R3 final alarm wake", int'(shdn_out), 0);
    cyc(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule